// File: doc/BRIEF.md
# Dual-Clock FIFO with Synchronized Status Flags

This block carries 36-bit words from one clock domain to another, unrelated one. Words are written on the write clock and stored in a 64-entry array. On the read clock, each accepted read moves the oldest word into a registered data output. The write and read pointers cross between the domains as Gray codes, and each crossing passes two flip-flop stages in the receiving domain.

Four active-low status flags tell each side what it may do. Full and almost-full belong to the write clock. Empty and almost-empty belong to the read clock. A write attempted while full is low has no effect. A read attempted while empty is low has no effect. The almost threshold X is one of four presets. It is taken from a two-bit select input when reset is released.

Reset is active-low. It can be asserted at any time, with no relation to either clock. Its release is synchronized separately in each domain. The user holds reset low for at least four edges of each clock, then waits for the full flag to rise before writing.

Top module: `dcf_fifo`

## Requirements
- R1: A write presented while `full_n` is low is discarded. The word is never stored, and the number of words that can later be read stays unchanged.
- R2: A read presented while `empty_n` is low has no effect. `rd_data` keeps its value and the read position does not advance, so the next word written is the next word read.
- R3: Words leave on `rd_data` in the order in which they were accepted, with all 36 bits intact.
- R4: The FIFO holds exactly 64 words. `full_n` stays high at 63 stored words and goes low right after the write edge that stores the 64th.
- R5: After a write into an empty FIFO, `empty_n` is still low after the first following read-clock edge and is high after the second. A read requested right after that places the word on `rd_data` at the third read-clock edge.
- R6: After a read from a full FIFO, `full_n` is still low after the first following write-clock edge and is high after the second.
- R7: `aempty_n` is low while the FIFO holds X or fewer words and high at X+1 or more. After the write that reaches X+1, the flag is still low after the first read-clock edge and high after the second. Whenever `empty_n` is low, `aempty_n` is low too.
- R8: `afull_n` is low while the free space is X or fewer entries and high otherwise, and it updates right after the write edge that changes the fill.
- R9: Driving `rst_n` low immediately sets `full_n`, `empty_n` and `aempty_n` low and `afull_n` high, with no clock edge needed. It also discards all stored words.
- R10: After `rst_n` rises, `full_n` is still low after the first write-clock edge and high after the second. `empty_n` stays low.
- R11: X is taken from `fs` while reset is held and frozen at release. The codes map as 2'b00 to 8, 2'b01 to 16, 2'b10 to 4 and 2'b11 to 32. Changing `fs` after release has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock, unrelated to wclk |
| rst_n | input | 1 | Active-low reset; assertion is asynchronous |
| fs | input | 2 | Preset select for the almost threshold, captured at reset release |
| wr_en | input | 1 | Write request, sampled on wclk |
| wr_data | input | 36 | Word to store |
| full_n | output | 1 | Low when no entry is free (write domain) |
| afull_n | output | 1 | Low when X or fewer entries are free (write domain) |
| rd_en | input | 1 | Read request, sampled on rclk |
| rd_data | output | 36 | Registered output word |
| empty_n | output | 1 | Low when no word can be read (read domain) |
| aempty_n | output | 1 | Low when X or fewer words are stored (read domain) |

## Verification
Single words are written into an empty FIFO, and the flag is sampled edge by edge on the other clock. This shows whether the pointer crossing takes two stages, or one or three. Directed bursts stop exactly one word below and at each threshold: X, X+1, 64-X, 63 and 64 words. Repeating them under several select codes tells apart a wrong compare direction, a wrong preset, and a preset that follows `fs` after release. Writes beyond capacity, reads on an empty FIFO, and a reset dropped between clock edges show that ignored operations and reset leave nothing behind. Finally, a long phase of interleaved traffic with fixed-seed random request rates exercises the queue. Its rates are first biased toward filling the FIFO and then toward draining it, so it reaches both full and empty, and every word read is compared against a model queue.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DATA_W_DEF = 36;
    localparam int ADDR_W_DEF = 6;
    localparam int CALC_W     = 32;

    // Preset codes for the almost threshold
    typedef enum logic [1:0] {
        SEL_EIGHT   = 2'b00,
        SEL_SIXTEEN = 2'b01,
        SEL_FOUR    = 2'b10,
        SEL_THIRTY2 = 2'b11
    } fsel_e;

    typedef struct packed {
        logic full_n;
        logic afull_n;
    } wflags_t;

    typedef struct packed {
        logic empty_n;
        logic aempty_n;
    } rflags_t;

    function automatic logic [CALC_W-1:0] to_gray(input logic [CALC_W-1:0] b);
        return b ^ (b >> 1);
    endfunction

    // Prefix-xor decode; upper zero bits leave narrower codes intact
    function automatic logic [CALC_W-1:0] from_gray(input logic [CALC_W-1:0] g);
        logic [CALC_W-1:0] b;
        b = g;
        for (int s = 1; s < CALC_W; s = s * 2) begin
            b = b ^ (b >> s);
        end
        return b;
    endfunction

    function automatic int unsigned offset_of(input logic [1:0] sel);
        case (fsel_e'(sel))
            SEL_EIGHT:   return 8;
            SEL_SIXTEEN: return 16;
            SEL_FOUR:    return 4;
            default:     return 32;
        endcase
    endfunction

endpackage

// File: rtl/dcf_rst_sync.sv
module dcf_rst_sync (
    input  logic clk,
    input  logic rst_n,
    output logic ok
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            ok     <= 1'b0;
        end else begin
            stage1 <= 1'b1;
            ok     <= stage1;
        end
    end
endmodule

// File: rtl/dcf_sync.sv
module dcf_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ok,
    input  logic [1:0]        fs,
    input  logic              req,
    input  logic [ADDR_W:0]   rgray_s,
    output logic [ADDR_W:0]   wptr,
    output logic [ADDR_W:0]   wgray,
    output logic [ADDR_W-1:0] waddr,
    output logic              accept,
    output wflags_t           flags
);
    localparam int PTR_W = ADDR_W + 1;
    localparam int DEPTH = 1 << ADDR_W;

    logic [PTR_W-1:0] thresh;
    logic [PTR_W-1:0] rbin;
    logic [PTR_W-1:0] fill;
    logic [PTR_W-1:0] space;
    logic [PTR_W-1:0] wptr_inc;

    // Preset follows fs while the local reset is held, frozen afterwards
    always_ff @(posedge clk) begin
        if (!ok) thresh <= PTR_W'(offset_of(fs));
    end

    always_comb begin
        rbin        = PTR_W'(from_gray(CALC_W'(rgray_s)));
        fill        = wptr - rbin;
        space       = PTR_W'(DEPTH) - fill;
        flags.full_n  = ok & (fill != PTR_W'(DEPTH));
        flags.afull_n = ~ok | (space > thresh);
        accept      = req & flags.full_n;
        wptr_inc    = wptr + 1'b1;
        waddr       = wptr[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            wgray <= '0;
        end else if (accept) begin
            wptr  <= wptr_inc;
            wgray <= PTR_W'(to_gray(CALC_W'(wptr_inc)));
        end
    end
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl
    import dcf_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ok,
    input  logic [1:0]        fs,
    input  logic              req,
    input  logic [ADDR_W:0]   wgray_s,
    output logic [ADDR_W:0]   rptr,
    output logic [ADDR_W:0]   rgray,
    output logic [ADDR_W-1:0] raddr,
    output logic              accept,
    output rflags_t           flags
);
    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0] thresh;
    logic [PTR_W-1:0] wbin;
    logic [PTR_W-1:0] fill;
    logic [PTR_W-1:0] rptr_inc;

    always_ff @(posedge clk) begin
        if (!ok) thresh <= PTR_W'(offset_of(fs));
    end

    always_comb begin
        wbin           = PTR_W'(from_gray(CALC_W'(wgray_s)));
        fill           = wbin - rptr;
        flags.empty_n  = ok & (fill != '0);
        flags.aempty_n = ok & (fill > thresh);
        accept         = req & flags.empty_n;
        rptr_inc       = rptr + 1'b1;
        raddr          = rptr[ADDR_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rptr  <= '0;
            rgray <= '0;
        end else if (accept) begin
            rptr  <= rptr_inc;
            rgray <= PTR_W'(to_gray(CALC_W'(rptr_inc)));
        end
    end
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n)  rdata <= '0;
        else if (re) rdata <= store[raddr];
    end
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo
    import dcf_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int DATA_W = DATA_W_DEF
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst_n,
    input  logic [1:0]        fs,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              empty_n,
    output logic              aempty_n
);
    localparam int PTR_W = ADDR_W + 1;

    logic              w_ok, r_ok;
    logic [PTR_W-1:0]  wr_ptr_bin, rd_ptr_bin;
    logic [PTR_W-1:0]  wr_gray, rd_gray;
    logic [PTR_W-1:0]  wr_gray_in_r, rd_gray_in_w;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              w_acc, r_acc;
    wflags_t           wfl;
    rflags_t           rfl;

    dcf_rst_sync u_wrst (.clk(wclk), .rst_n(rst_n), .ok(w_ok));
    dcf_rst_sync u_rrst (.clk(rclk), .rst_n(rst_n), .ok(r_ok));

    dcf_sync #(.W(PTR_W)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_in_w)
    );
    dcf_sync #(.W(PTR_W)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_in_r)
    );

    dcf_wr_ctrl #(.ADDR_W(ADDR_W)) u_wctl (
        .clk(wclk), .rst_n(rst_n), .ok(w_ok), .fs(fs), .req(wr_en),
        .rgray_s(rd_gray_in_w), .wptr(wr_ptr_bin), .wgray(wr_gray),
        .waddr(waddr), .accept(w_acc), .flags(wfl)
    );

    dcf_rd_ctrl #(.ADDR_W(ADDR_W)) u_rctl (
        .clk(rclk), .rst_n(rst_n), .ok(r_ok), .fs(fs), .req(rd_en),
        .wgray_s(wr_gray_in_r), .rptr(rd_ptr_bin), .rgray(rd_gray),
        .raddr(raddr), .accept(r_acc), .flags(rfl)
    );

    dcf_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
        .wclk(wclk), .we(w_acc), .waddr(waddr), .wdata(wr_data),
        .rclk(rclk), .rst_n(rst_n), .re(r_acc), .raddr(raddr),
        .rdata(rd_data)
    );

    assign full_n   = wfl.full_n;
    assign afull_n  = wfl.afull_n;
    assign empty_n  = rfl.empty_n;
    assign aempty_n = rfl.aempty_n;
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 36
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst_n,
    input logic              full_n,
    input logic              afull_n,
    input logic              empty_n,
    input logic              aempty_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W:0]   wptr,
    input logic [ADDR_W:0]   rptr
);
    assert_no_write_when_full_R1: assert property (
        @(posedge wclk) disable iff (!rst_n) (!full_n) |=> $stable(wptr)
    );

    assert_rptr_hold_when_empty_R2: assert property (
        @(posedge rclk) disable iff (!rst_n) (!empty_n) |=> $stable(rptr)
    );

    assert_rdata_hold_when_empty_R2: assert property (
        @(posedge rclk) disable iff (!rst_n) (!empty_n) |=> $stable(rd_data)
    );

    assert_empty_implies_aempty_R7: assert property (
        @(posedge rclk) disable iff (!rst_n) (!empty_n) |-> (!aempty_n)
    );

    always @(posedge wclk) begin
        if (rst_n === 1'b0) begin
            assert_reset_wflags_R9: assert (!full_n && afull_n);
        end
    end

    always @(posedge rclk) begin
        if (rst_n === 1'b0) begin
            assert_reset_rflags_R9: assert (!empty_n && !aempty_n);
        end
    end
endmodule

bind dcf_fifo dcf_fifo_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n),
    .full_n(full_n), .afull_n(afull_n),
    .empty_n(empty_n), .aempty_n(aempty_n),
    .rd_data(rd_data), .wptr(wr_ptr_bin), .rptr(rd_ptr_bin)
);

// File: tb/dcf_fifo_tb.sv
`timescale 1ns/100ps
module dcf_fifo_tb;
    localparam int DW = 36;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n, wr_en, rd_en;
    logic [1:0]    fs;
    logic [DW-1:0] wr_data, rd_data;
    logic          full_n, afull_n, empty_n, aempty_n;

    int            total = 0;
    int            bad = 0;
    logic [DW-1:0] q[$];
    bit            wdone;
    bit            saw_full;

    always #5 wclk = ~wclk;              // 100 MHz, edges on whole ns
    initial begin
        #0.5;
        forever #7 rclk = ~rclk;         // edges on half ns, never coincide
    end

    dcf_fifo u_dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fs(fs),
        .wr_en(wr_en), .wr_data(wr_data), .full_n(full_n), .afull_n(afull_n),
        .rd_en(rd_en), .rd_data(rd_data), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] rnd_word();
        logic [63:0] v;
        v = {$urandom(), $urandom()};
        return v[DW-1:0];
    endfunction

    task automatic wr_word(input logic [DW-1:0] d, output bit acc);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        acc     = full_n;
        @(posedge wclk);
        if (acc) q.push_back(d);
    endtask

    task automatic wr_stop();
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic wr_burst(input int n);
        bit acc;
        for (int i = 0; i < n; i++) wr_word(rnd_word(), acc);
    endtask

    task automatic rd_word(output logic [DW-1:0] d, output bit acc);
        @(negedge rclk);
        rd_en = 1'b1;
        acc   = empty_n;
        @(posedge rclk);
        #1;
        rd_en = 1'b0;
        d     = rd_data;
    endtask

    task automatic rd_expect(input string tag);
        logic [DW-1:0] d;
        bit acc;
        rd_word(d, acc);
        if (!acc) check({tag, " read refused"}, 0, 1);
        else if (q.size() == 0) check({tag, " word beyond model"}, 1, 0);
        else check(tag, d, q.pop_front());
    endtask

    task automatic wait_r(input int n);
        repeat (n) @(posedge rclk);
        #1;
    endtask

    task automatic do_reset(input logic [1:0] sel);
        @(negedge wclk);
        rst_n = 1'b0;
        fs    = sel;
        #1;
        check("R9 full_n in reset", full_n, 0);
        check("R9 afull_n in reset", afull_n, 1);
        check("R9 empty_n in reset", empty_n, 0);
        check("R9 aempty_n in reset", aempty_n, 0);
        repeat (8) @(negedge wclk);
        rst_n = 1'b1;
        q.delete();
        @(posedge wclk); #1;
        check("R10 full_n after 1st edge", full_n, 0);
        @(posedge wclk); #1;
        check("R10 full_n after 2nd edge", full_n, 1);
        check("R10 empty_n after release", empty_n, 0);
        wait_r(2);
    endtask

    initial begin
        #1_500_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [DW-1:0] d, wa, wb;
        bit acc;
        void'($urandom(32'h1D5E_ED01));
        rst_n = 1'b1; wr_en = 1'b0; rd_en = 1'b0; fs = 2'b00; wr_data = '0;
        #1 rst_n = 1'b0;
        #1;
        check("R9 full_n at start", full_n, 0);
        check("R9 afull_n at start", afull_n, 1);
        check("R9 empty_n at start", empty_n, 0);
        check("R9 aempty_n at start", aempty_n, 0);

        // ---- X = 8 ----
        do_reset(2'b00);

        // R5 write-to-output latency
        wa = 36'h9_A5A5_0001;
        wr_word(wa, acc);
        fork
            wr_stop();
            begin
                @(posedge rclk); #1;
                check("R5 empty_n after 1st rclk", empty_n, 0);
                @(posedge rclk); #1;
                check("R5 empty_n after 2nd rclk", empty_n, 1);
            end
        join
        rd_word(d, acc);
        check("R5 read accepted", acc, 1);
        check("R5 word at 3rd rclk", d, wa);
        void'(q.pop_front());

        // R2 reads on empty are ignored
        for (int i = 0; i < 3; i++) begin
            rd_word(d, acc);
            check("R2 empty_n low", acc, 0);
            check("R2 rd_data held", d, wa);
        end
        wb = 36'h3_0F0F_0002;
        wr_word(wb, acc);
        wr_stop();
        wait_r(4);
        rd_word(d, acc);
        check("R2 next word after ignored reads", d, wb);
        void'(q.pop_front());

        // R7 almost-empty with X = 8
        wr_burst(8);
        wr_stop();
        wait_r(4);
        check("R7 aempty_n at fill 8", aempty_n, 0);
        check("R7 empty_n at fill 8", empty_n, 1);
        wr_word(rnd_word(), acc);
        fork
            wr_stop();
            begin
                @(posedge rclk); #1;
                check("R7 aempty_n 1st edge after fill 9", aempty_n, 0);
                @(posedge rclk); #1;
                check("R7 aempty_n 2nd edge after fill 9", aempty_n, 1);
            end
        join

        // R8 almost-full with X = 8
        wr_burst(45);
        wr_word(rnd_word(), acc);
        #1 check("R8 afull_n at free 9", afull_n, 1);
        wr_word(rnd_word(), acc);
        #1 check("R8 afull_n at free 8", afull_n, 0);

        // R4 capacity
        wr_burst(7);
        #1 check("R4 full_n at 63 words", full_n, 1);
        wr_word(rnd_word(), acc);
        #1 check("R4 full_n at 64 words", full_n, 0);

        // R1 writes while full are dropped
        for (int i = 0; i < 3; i++) begin
            wr_word(36'hF_DEAD_0000 + 36'(i), acc);
            check("R1 write refused when full", acc, 0);
        end
        wr_stop();

        // R6 full release timing
        @(negedge rclk);
        rd_en = 1'b1;
        @(posedge rclk);
        fork
            begin
                #1 rd_en = 1'b0;
                check("R6 R3 first word out of full FIFO", rd_data, q.pop_front());
            end
            begin
                @(posedge wclk); #1;
                check("R6 full_n 1st wclk after read", full_n, 0);
                @(posedge wclk); #1;
                check("R6 full_n 2nd wclk after read", full_n, 1);
            end
        join
        for (int i = 0; i < 63; i++) rd_expect("R3 drain order");
        wait_r(4);
        check("R1 no extra word stored", empty_n, 0);
        check("R7 aempty_n when empty", aempty_n, 0);

        // ---- X = 32, fs changed after release ----
        do_reset(2'b11);
        fs = 2'b10;
        wr_burst(32);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 32 (X=32)", aempty_n, 0);
        wr_word(rnd_word(), acc);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 33 (X=32)", aempty_n, 1);
        check("R11 afull_n at free 31 (X=32)", afull_n, 0);
        for (int i = 0; i < 33; i++) rd_expect("R3 drain X=32");

        // ---- X = 4 ----
        do_reset(2'b10);
        wr_burst(4);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 4 (X=4)", aempty_n, 0);
        wr_word(rnd_word(), acc);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 5 (X=4)", aempty_n, 1);
        wr_burst(54);
        #1 check("R11 afull_n at free 5 (X=4)", afull_n, 1);
        wr_word(rnd_word(), acc);
        #1 check("R11 afull_n at free 4 (X=4)", afull_n, 0);
        wr_stop();
        for (int i = 0; i < 60; i++) rd_expect("R3 drain X=4");

        // ---- X = 16, random traffic ----
        do_reset(2'b01);
        wdone = 1'b0;
        saw_full = 1'b0;
        fork
            begin
                bit a;
                for (int i = 0; i < 900; i++) begin
                    @(negedge wclk);
                    wr_en   = ($urandom_range(99) < 60);
                    wr_data = rnd_word();
                    if (!full_n) saw_full = 1'b1;
                    a = wr_en && full_n;
                    @(posedge wclk);
                    if (a) q.push_back(wr_data);
                end
                @(negedge wclk);
                wr_en = 1'b0;
                wdone = 1'b1;
            end
            begin
                bit a;
                int n;
                n = 0;
                while (!wdone || q.size() != 0) begin
                    @(negedge rclk);
                    rd_en = (n < 350) ? ($urandom_range(99) < 25)
                                      : ($urandom_range(99) < 90);
                    a = rd_en && empty_n;
                    @(posedge rclk);
                    #1;
                    if (a) begin
                        if (q.size() == 0) check("R3 random read beyond model", 1, 0);
                        else check("R3 random order", rd_data, q.pop_front());
                    end
                    n++;
                end
                rd_en = 1'b0;
            end
        join
        check("R4 random phase reached full", saw_full, 1);
        wait_r(4);
        check("R3 random phase ends empty", empty_n, 0);
        wr_burst(16);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 16 (X=16)", aempty_n, 0);
        wr_word(rnd_word(), acc);
        wr_stop();
        wait_r(4);
        check("R11 aempty_n at fill 17 (X=16)", aempty_n, 1);

        // R9 asynchronous reset between edges, contents discarded
        @(posedge wclk);
        #2 rst_n = 1'b0;
        #1;
        check("R9 async full_n", full_n, 0);
        check("R9 async afull_n", afull_n, 1);
        check("R9 async empty_n", empty_n, 0);
        check("R9 async aempty_n", aempty_n, 0);
        do_reset(2'b00);
        wait_r(4);
        check("R9 contents discarded", empty_n, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule